// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Token Controller

This block is the control for one slice of a deeper FIFO built by chaining several identical slices into a ring. Two tokens travel around the ring. Only the slice holding the write token accepts writes, and only the slice holding the read token supplies reads. The slice's storage array and its pointer logic sit outside this block. That logic tells the controller when the next access hits the last physical location. On that access the slice hands the matching token on by sending a one-cycle expansion pulse to its neighbour. The neighbour takes the token when it samples the pulse on its own clock.

A strap input picks the slice that starts with both tokens after reset. Tie the strap low on exactly one slice in the ring and high on all the others. The block also gates the slice's output drive, so only the slice that holds the read token drives the shared read bus. It combines the active-low status flags of every slice into group flags. It also shares one output pin between the half-full flag (standalone use) and the write expansion pulse (cascade use).

Top module: `depthRingSlice`

## Requirements
- R1: While reset is asserted, and after it is released, a slice whose strap `firstLoadN` is 0 holds both the write and the read token. A slice whose strap is 1 holds neither token. Both expansion outputs are 0.
- R2: `wrEnGated` equals `wrReq` AND (write token held). `rdEnGated` equals `rdReq` AND (read token held).
- R3: On a write-clock edge where `wrEnGated` and `wrLastLoc` are both 1, the slice drops the write token. `wrExpOut` is then 1 for exactly the following write-clock cycle.
- R4: On a read-clock edge where `rdEnGated` and `rdLastLoc` are both 1, the slice drops the read token. `rdExpOut` is then 1 for exactly the following read-clock cycle.
- R5: A slice that does not hold a token and samples the matching expansion input at 1 on its own clock edge holds that token after the edge.
- R6: In a ring of slices, each token is at every cycle either held by exactly one slice or in flight as exactly one expansion pulse. Data read across the ring comes out in the order it was written, across slice boundaries and ring wraparound.
- R7: `rdDataDrive` equals `outEn` AND (read token held). A slice that does not hold the read token never drives, whatever the value of `outEn`.
- R8: When `cascadeMode` is 1, `xoOrHalfN` carries `wrExpOut`. When it is 0, it carries `sliceHalfN`.
- R9: Each group flag output (empty, full, almost empty, almost full; all active low) is 0 only when every bit of its peer vector is 0. The four flags are independent of each other.
- R10: A slice holding a token keeps it across any edge on which it does not access its last location with that token. No pulse is produced on such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| firstLoadN | input | 1 | Strap; 0 makes this slice the initial owner of both tokens |
| cascadeMode | input | 1 | 1 selects the write expansion pulse on the shared pin |
| wrExpIn | input | 1 | Write expansion input from the previous slice |
| rdExpIn | input | 1 | Read expansion input from the previous slice |
| wrReq | input | 1 | Local write request |
| rdReq | input | 1 | Local read request |
| wrLastLoc | input | 1 | Next write targets the last physical location |
| rdLastLoc | input | 1 | Next read targets the last physical location |
| outEn | input | 1 | Output enable request for the read bus |
| sliceHalfN | input | 1 | This slice's active-low half-full flag |
| peerEmptyN | input | NUM_PEERS | Active-low empty flags of all slices |
| peerFullN | input | NUM_PEERS | Active-low full flags of all slices |
| peerAlmostEmptyN | input | NUM_PEERS | Active-low almost-empty flags of all slices |
| peerAlmostFullN | input | NUM_PEERS | Active-low almost-full flags of all slices |
| wrExpOut | output | 1 | Write token hand-off pulse |
| rdExpOut | output | 1 | Read token hand-off pulse |
| wrEnGated | output | 1 | Write enable to the local storage |
| rdEnGated | output | 1 | Read enable to the local storage |
| rdDataDrive | output | 1 | Drive enable for the shared read bus |
| xoOrHalfN | output | 1 | Shared pin: write pulse or half-full flag |
| wrTokenHeld | output | 1 | This slice holds the write token |
| rdTokenHeld | output | 1 | This slice holds the read token |
| grpEmptyN | output | 1 | Group empty, active low |
| grpFullN | output | 1 | Group full, active low |
| grpAlmostEmptyN | output | 1 | Group almost empty, active low |
| grpAlmostFullN | output | 1 | Group almost full, active low |

## Verification
The hardest case to reach is the ring wrapping around while reads and writes run at the same time. In that state the write token re-enters a slice that still holds unread words, and both tokens may be in flight on the same cycle. The bench builds a three-slice ring of four-word slices and models the storage and pointers itself. It fills the whole ring, drains it, and then runs a long interleaved stream with uneven read and write duty cycles. The tokens therefore lap the ring many times at different phases. On every cycle it checks token conservation, pulse width and the order of the data read out.

// File: rtl/ringSlicePkg.sv
package ringSlicePkg;
  // Strobes passed from token control to the slice datapath
  typedef struct packed {
    logic wrHold;
    logic rdHold;
    logic wrGrant;
    logic rdGrant;
    logic wrPass;
    logic rdPass;
  } sliceStrobeT;

  localparam int FLAG_KINDS = 4;
endpackage

// File: rtl/tokenKeeper.sv
module tokenKeeper (
  input  logic clk,
  input  logic rstN,
  input  logic ownAtReset,
  input  logic takeIn,
  input  logic req,
  input  logic lastLoc,
  output logic hold,
  output logic grant,
  output logic pass
);
  assign grant = hold & req;
  assign pass  = grant & lastLoc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hold <= ownAtReset;
    else if (pass)   hold <= 1'b0;
    else if (takeIn) hold <= 1'b1;
  end

  // R3 / R4: last-location access hands the token on
  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    (hold && req && lastLoc) |=> !hold);
  // R5: an incoming pulse is taken on this clock
  a_r5_take: assert property (@(posedge clk) disable iff (!rstN)
    (!hold && takeIn) |=> hold);
  // R10: token kept when not leaving the last location
  a_r10_keep: assert property (@(posedge clk) disable iff (!rstN)
    (hold && !(req && lastLoc)) |=> hold);
endmodule

// File: rtl/ringTokenCtrl.sv
module ringTokenCtrl
  import ringSlicePkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        firstLoadN,
  input  logic        wrExpIn,
  input  logic        rdExpIn,
  input  logic        wrReq,
  input  logic        rdReq,
  input  logic        wrLastLoc,
  input  logic        rdLastLoc,
  output sliceStrobeT strobes
);
  localparam int SIDES = 2;

  logic [SIDES-1:0] clkV, takeV, reqV, lastV, holdV, grantV, passV;

  assign clkV  = {rdClk, wrClk};
  assign takeV = {rdExpIn, wrExpIn};
  assign reqV  = {rdReq, wrReq};
  assign lastV = {rdLastLoc, wrLastLoc};

  // index 0 = write side, index 1 = read side
  for (genvar side = 0; side < SIDES; side++) begin : g_side
    tokenKeeper keeper (
      .clk        (clkV[side]),
      .rstN       (rstN),
      .ownAtReset (~firstLoadN),
      .takeIn     (takeV[side]),
      .req        (reqV[side]),
      .lastLoc    (lastV[side]),
      .hold       (holdV[side]),
      .grant      (grantV[side]),
      .pass       (passV[side])
    );
  end

  always_comb begin
    strobes.wrHold  = holdV[0];
    strobes.rdHold  = holdV[1];
    strobes.wrGrant = grantV[0];
    strobes.rdGrant = grantV[1];
    strobes.wrPass  = passV[0];
    strobes.rdPass  = passV[1];
  end
endmodule

// File: rtl/sliceDatapath.sv
module sliceDatapath
  import ringSlicePkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  sliceStrobeT strobes,
  input  logic        cascadeMode,
  input  logic        outEn,
  input  logic        sliceHalfN,
  output logic        wrExpOut,
  output logic        rdExpOut,
  output logic        wrEnGated,
  output logic        rdEnGated,
  output logic        rdDataDrive,
  output logic        xoOrHalfN,
  output logic        wrTokenHeld,
  output logic        rdTokenHeld
);
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrExpOut <= 1'b0;
    else       wrExpOut <= strobes.wrPass;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdExpOut <= 1'b0;
    else       rdExpOut <= strobes.rdPass;
  end

  assign wrEnGated   = strobes.wrGrant;
  assign rdEnGated   = strobes.rdGrant;
  assign rdDataDrive = strobes.rdHold & outEn;
  assign xoOrHalfN   = cascadeMode ? wrExpOut : sliceHalfN;
  assign wrTokenHeld = strobes.wrHold;
  assign rdTokenHeld = strobes.rdHold;

  // R3: write pulse lasts exactly one cycle
  a_r3_wr_pulse: assert property (@(posedge wrClk) disable iff (!rstN)
    strobes.wrPass |=> (wrExpOut && !strobes.wrHold));
  a_r3_wr_single: assert property (@(posedge wrClk) disable iff (!rstN)
    wrExpOut |=> !wrExpOut);
  // R4: read pulse lasts exactly one cycle
  a_r4_rd_pulse: assert property (@(posedge rdClk) disable iff (!rstN)
    strobes.rdPass |=> (rdExpOut && !strobes.rdHold));
  a_r4_rd_single: assert property (@(posedge rdClk) disable iff (!rstN)
    rdExpOut |=> !rdExpOut);
endmodule

// File: rtl/flagMerge.sv
module flagMerge #(
  parameter int NUM_PEERS = 3,
  parameter int KINDS     = 4
) (
  input  logic [KINDS-1:0][NUM_PEERS-1:0] peerFlagsN,
  output logic [KINDS-1:0]                groupN
);
  // Active-low flags: group asserts only when every slice asserts
  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign groupN[k] = |peerFlagsN[k];
  end
endmodule

// File: rtl/depthRingSlice.sv
module depthRingSlice
  import ringSlicePkg::*;
#(
  parameter int NUM_PEERS = 3
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rstN,
  input  logic                 firstLoadN,
  input  logic                 cascadeMode,
  input  logic                 wrExpIn,
  input  logic                 rdExpIn,
  input  logic                 wrReq,
  input  logic                 rdReq,
  input  logic                 wrLastLoc,
  input  logic                 rdLastLoc,
  input  logic                 outEn,
  input  logic                 sliceHalfN,
  input  logic [NUM_PEERS-1:0] peerEmptyN,
  input  logic [NUM_PEERS-1:0] peerFullN,
  input  logic [NUM_PEERS-1:0] peerAlmostEmptyN,
  input  logic [NUM_PEERS-1:0] peerAlmostFullN,
  output logic                 wrExpOut,
  output logic                 rdExpOut,
  output logic                 wrEnGated,
  output logic                 rdEnGated,
  output logic                 rdDataDrive,
  output logic                 xoOrHalfN,
  output logic                 wrTokenHeld,
  output logic                 rdTokenHeld,
  output logic                 grpEmptyN,
  output logic                 grpFullN,
  output logic                 grpAlmostEmptyN,
  output logic                 grpAlmostFullN
);
  sliceStrobeT strobes;
  logic [FLAG_KINDS-1:0][NUM_PEERS-1:0] peerFlagsN;
  logic [FLAG_KINDS-1:0]                groupN;

  ringTokenCtrl ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrExpIn(wrExpIn), .rdExpIn(rdExpIn), .wrReq(wrReq), .rdReq(rdReq),
    .wrLastLoc(wrLastLoc), .rdLastLoc(rdLastLoc), .strobes(strobes)
  );

  sliceDatapath dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .cascadeMode(cascadeMode), .outEn(outEn), .sliceHalfN(sliceHalfN),
    .wrExpOut(wrExpOut), .rdExpOut(rdExpOut), .wrEnGated(wrEnGated),
    .rdEnGated(rdEnGated), .rdDataDrive(rdDataDrive), .xoOrHalfN(xoOrHalfN),
    .wrTokenHeld(wrTokenHeld), .rdTokenHeld(rdTokenHeld)
  );

  assign peerFlagsN = {peerAlmostFullN, peerAlmostEmptyN, peerFullN, peerEmptyN};

  flagMerge #(.NUM_PEERS(NUM_PEERS), .KINDS(FLAG_KINDS)) merge (
    .peerFlagsN(peerFlagsN), .groupN(groupN)
  );

  assign grpEmptyN       = groupN[0];
  assign grpFullN        = groupN[1];
  assign grpAlmostEmptyN = groupN[2];
  assign grpAlmostFullN  = groupN[3];
endmodule

// File: tb/tb_depthRingSlice.sv
module tb_depthRingSlice;
  localparam int NS    = 3;
  localparam int DEPTH = 4;
  localparam int CAP   = NS * DEPTH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cascadeMode, outEn, sliceHalfN;
  logic wrReqR, rdReqR;
  logic [NS-1:0] vEmpty, vFull, vAe, vAf;
  logic wrXo [NS], rdXo [NS], wrEn [NS], rdEn [NS], drive [NS], shared [NS];
  logic wrTok [NS], rdTok [NS], gE [NS], gF [NS], gAe [NS], gAf [NS];
  logic wrLast [NS], rdLast [NS];

  int mem [NS][DEPTH];
  int wrPtr [NS], rdPtr [NS];
  logic recWr [NS], recRd [NS], prevWrXo [NS], prevRdXo [NS];
  int wrData, expRd, count;
  int nChecks = 0, nFails = 0;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    assign wrLast[s] = (wrPtr[s] == DEPTH - 1);
    assign rdLast[s] = (rdPtr[s] == DEPTH - 1);
    depthRingSlice #(.NUM_PEERS(NS)) dut (
      .wrClk(clk), .rdClk(clk), .rstN(rstN), .firstLoadN(s != 0),
      .cascadeMode(cascadeMode),
      .wrExpIn(wrXo[(s + NS - 1) % NS]), .rdExpIn(rdXo[(s + NS - 1) % NS]),
      .wrReq(wrReqR), .rdReq(rdReqR), .wrLastLoc(wrLast[s]), .rdLastLoc(rdLast[s]),
      .outEn(outEn), .sliceHalfN(sliceHalfN),
      .peerEmptyN(vEmpty), .peerFullN(vFull), .peerAlmostEmptyN(vAe), .peerAlmostFullN(vAf),
      .wrExpOut(wrXo[s]), .rdExpOut(rdXo[s]), .wrEnGated(wrEn[s]), .rdEnGated(rdEn[s]),
      .rdDataDrive(drive[s]), .xoOrHalfN(shared[s]),
      .wrTokenHeld(wrTok[s]), .rdTokenHeld(rdTok[s]),
      .grpEmptyN(gE[s]), .grpFullN(gF[s]), .grpAlmostEmptyN(gAe[s]), .grpAlmostFullN(gAf[s])
    );
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit wantWr, input bit wantRd);
    int wSum, rSum;
    @(negedge clk);
    // effects of the previous edge
    for (int s = 0; s < NS; s++) if (recWr[s]) begin
      mem[s][wrPtr[s]] = wrData;
      wrPtr[s] = (wrPtr[s] + 1) % DEPTH;
      wrData++; count++;
    end
    for (int s = 0; s < NS; s++) if (recRd[s]) begin
      check(mem[s][rdPtr[s]] == expRd, "R6 read order", mem[s][rdPtr[s]], expRd);
      rdPtr[s] = (rdPtr[s] + 1) % DEPTH;
      expRd++; count--;
    end
    wSum = 0; rSum = 0;
    for (int s = 0; s < NS; s++) begin
      wSum += int'(wrTok[s]) + int'(wrXo[s]);
      rSum += int'(rdTok[s]) + int'(rdXo[s]);
      if (prevWrXo[s]) begin
        check(!wrXo[s], "R3 write pulse width", int'(wrXo[s]), 0);
        check(wrTok[(s + 1) % NS], "R5 write token taken", int'(wrTok[(s + 1) % NS]), 1);
      end
      if (prevRdXo[s]) begin
        check(!rdXo[s], "R4 read pulse width", int'(rdXo[s]), 0);
        check(rdTok[(s + 1) % NS], "R5 read token taken", int'(rdTok[(s + 1) % NS]), 1);
      end
      if (recWr[s] && wrLast[s] == 1'b0 && wrPtr[s] == 0)
        check(wrXo[s] && !wrTok[s], "R3 write hand-off", int'(wrXo[s]), 1);
      if (recRd[s] && rdPtr[s] == 0)
        check(rdXo[s] && !rdTok[s], "R4 read hand-off", int'(rdXo[s]), 1);
      check(drive[s] == (rdTok[s] & outEn), "R7 drive gating", int'(drive[s]), int'(rdTok[s] & outEn));
      prevWrXo[s] = wrXo[s];
      prevRdXo[s] = rdXo[s];
    end
    check(wSum == 1, "R6 write token conservation", wSum, 1);
    check(rSum == 1, "R6 read token conservation", rSum, 1);
    wrReqR = wantWr && (count < CAP);
    rdReqR = wantRd && (count > 0);
    #1;
    for (int s = 0; s < NS; s++) begin
      check(wrEn[s] == (wrReqR & wrTok[s]), "R2 write gating", int'(wrEn[s]), int'(wrReqR & wrTok[s]));
      check(rdEn[s] == (rdReqR & rdTok[s]), "R2 read gating", int'(rdEn[s]), int'(rdReqR & rdTok[s]));
      recWr[s] = wrEn[s];
      recRd[s] = rdEn[s];
    end
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cascadeMode = 1'b1; outEn = 1'b1; sliceHalfN = 1'b1;
    wrReqR = 1'b0; rdReqR = 1'b0;
    vEmpty = '1; vFull = '1; vAe = '1; vAf = '1;
    wrData = 0; expRd = 0; count = 0;
    for (int s = 0; s < NS; s++) begin
      wrPtr[s] = 0; rdPtr[s] = 0; recWr[s] = 0; recRd[s] = 0;
      prevWrXo[s] = 0; prevRdXo[s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset ownership
    for (int s = 0; s < NS; s++) begin
      check(wrTok[s] == (s == 0), "R1 write token after reset", int'(wrTok[s]), int'(s == 0));
      check(rdTok[s] == (s == 0), "R1 read token after reset", int'(rdTok[s]), int'(s == 0));
      check(!wrXo[s] && !rdXo[s], "R1 expansion outputs idle", int'(wrXo[s] | rdXo[s]), 0);
    end
    // R10 idle keeps tokens
    repeat (4) step(0, 0);
    check(wrTok[0] && rdTok[0], "R10 tokens kept when idle", int'(wrTok[0] & rdTok[0]), 1);
    // R7 output enable on non-owners
    outEn = 1'b0; #1;
    for (int s = 0; s < NS; s++) check(!drive[s], "R7 drive off", int'(drive[s]), 0);
    outEn = 1'b1; #1;
    check(drive[0] && !drive[1] && !drive[2], "R7 only owner drives", int'(drive[1] | drive[2]), 0);
    // fill the whole ring, then drain it
    repeat (CAP + 6) step(1, 0);
    check(count == CAP, "R6 ring filled", count, CAP);
    check(wrTok[0], "R6 write token lapped to first slice", int'(wrTok[0]), 1);
    repeat (CAP + 6) step(0, 1);
    check(count == 0, "R6 ring drained", count, 0);
    // interleaved traffic
    for (int i = 0; i < 400; i++) begin
      outEn = (i % 5) != 0;
      step((i % 3) != 0, (i % 7) < 4);
    end
    repeat (CAP + 8) step(0, 1);
    check(expRd == wrData && count == 0, "R6 all words read in order", expRd, wrData);
    check(wrData > 3 * CAP, "R6 several laps", wrData, 3 * CAP);
    // R9 composite flag sweep
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < (1 << NS); v++) begin
        vEmpty = '1; vFull = '1; vAe = '1; vAf = '1;
        case (k)
          0: vEmpty = v[NS-1:0];
          1: vFull  = v[NS-1:0];
          2: vAe    = v[NS-1:0];
          default: vAf = v[NS-1:0];
        endcase
        #1;
        check(gE[0] == (k == 0 ? (v != 0) : 1'b1), "R9 group empty", int'(gE[0]), int'(k == 0 ? (v != 0) : 1'b1));
        check(gF[1] == (k == 1 ? (v != 0) : 1'b1), "R9 group full", int'(gF[1]), int'(k == 1 ? (v != 0) : 1'b1));
        check(gAe[2] == (k == 2 ? (v != 0) : 1'b1), "R9 group almost empty", int'(gAe[2]), int'(k == 2 ? (v != 0) : 1'b1));
        check(gAf[0] == (k == 3 ? (v != 0) : 1'b1), "R9 group almost full", int'(gAf[0]), int'(k == 3 ? (v != 0) : 1'b1));
      end
    end
    // R8 shared pin
    cascadeMode = 1'b0;
    for (int h = 0; h < 2; h++) begin
      sliceHalfN = h[0]; #1;
      for (int s = 0; s < NS; s++) check(shared[s] == h[0], "R8 half-full on shared pin", int'(shared[s]), h);
    end
    cascadeMode = 1'b1; sliceHalfN = 1'b0; #1;
    for (int s = 0; s < NS; s++) check(shared[s] == wrXo[s], "R8 pulse on shared pin", int'(shared[s]), int'(wrXo[s]));
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule